// File: doc/BRIEF.md
# Oscillator Startup Clock-Release Sequencer

This block brings a crystal oscillator up from power-down and decides when its clock may be handed to downstream logic. A power-down request switches the oscillator enable off or on. On every power-up the block measures two independent waits on a common time unit of 0.25 ms. The first wait ends with the oscillator reported stable. The second ends with the clock released to the logic that depends on it. Each wait is selected by its own delay code.

The time unit is a whole number of clock cycles, set by a parameter. A detector-enable input qualifies a crystal-ok status. An override input holds the clock ungated at all times, whatever the power state. The clock-release output drives an external glitch-free gate cell. The oscillator itself is not modelled here.

Top module: `osc_startup_seq`

## Requirements
- R1: After reset the oscillator enable, the stable status, the crystal-ok status and the clock release are all 0.
- R2: With the power-down input at 0, the oscillator enable rises at the next clock edge. With the power-down input at 1, the oscillator enable, the stable status and the crystal-ok status are all 0 after the next edge. The clock release is also 0 after that edge unless the override is 1.
- R3: The 2-bit stabilisation code picks a wait of 1, 2, 4 or 8 units for codes 0, 1, 2 and 3. The stable status rises exactly wait×UNIT_CYCLES+1 cycles after the oscillator enable rises.
- R4: The 3-bit release code picks a wait of 2 units for code 0 and 4×code units for codes 1 to 7. The clock release rises exactly wait×UNIT_CYCLES+2 cycles after the oscillator enable rises.
- R5: The stable status is 1 only while the oscillator enable is 1. Once set, it stays 1 until the next power-down.
- R6: With the detector enable at 1, the crystal-ok status follows the stable status one cycle later. With the detector enable at 0, the crystal-ok status is 0 after the next edge.
- R7: With the override at 1, the clock release is 1 after the next edge, whether the oscillator is powered or not.
- R8: Both delay codes are captured in the cycle that power-up begins. A code change during a wait has no effect until the next power-up.
- R9: Every power-up restarts both waits from zero. A power-down in the middle of a wait discards the time already counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the timing reference |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwr_down | input | 1 | 1 requests the oscillator off, 0 requests it on |
| stab_code | input | 2 | Stabilisation wait select |
| rel_code | input | 3 | Clock-release wait select |
| gate_override | input | 1 | 1 keeps the clock permanently released |
| detect_en | input | 1 | Enables the crystal-ok status |
| osc_power_en | output | 1 | Oscillator power enable |
| osc_stable | output | 1 | Stabilisation wait elapsed |
| xtal_ok | output | 1 | Stable status qualified by the detector enable |
| clk_release_en | output | 1 | Enable for the downstream clock gate |

## Verification
The assertions check the cycle-local rules on every clock: stable only while powered, power-down clearing the status outputs on the next edge, the override forcing release, the detector gate, codes held constant during a wait, restart clearing the unit count, and a wait flag never rising before its unit target. The exact lengths of the stabilisation and release waits for each code are shown only by the bench scenarios, which measure the edge distances. The same is true of the proof that a mid-wait code change is ignored and that an interrupted wait restarts in full.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;
  // Longest wait in units (release code 7 = 28 units of 0.25 ms)
  localparam int MAX_UNITS = 28;
  localparam int UNIT_W    = $clog2(MAX_UNITS + 1);

  typedef enum logic [1:0] {
    PWR_OFF   = 2'd0,
    PWR_WAIT  = 2'd1,
    PWR_READY = 2'd2
  } pwr_state_t;

  // Stabilisation wait: 1, 2, 4 or 8 units
  function automatic logic [UNIT_W-1:0] stab_units(input logic [1:0] code);
    return UNIT_W'(1) << code;
  endfunction

  // Release wait: 2 units for code 0, else 4 units per code step
  function automatic logic [UNIT_W-1:0] rel_units(input logic [2:0] code);
    return (code == 3'd0) ? UNIT_W'(2) : UNIT_W'({code, 2'b00});
  endfunction
endpackage

// File: rtl/osc_unit_timer.sv
module osc_unit_timer #(
  parameter int UNIT_CYCLES = 50000,
  parameter int MAX_UNITS   = 28,
  parameter int UW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  output logic [UW-1:0] units
);
  localparam int PW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;

  logic [PW-1:0] presc_q, presc_d;
  logic [UW-1:0] units_q, units_d;
  logic          unit_end;

  assign unit_end = (presc_q == PW'(UNIT_CYCLES - 1));

  always_comb begin
    presc_d = presc_q;
    units_d = units_q;
    if (clear) begin
      presc_d = '0;
      units_d = '0;
    end else if (run) begin
      if (unit_end) begin
        presc_d = '0;
        if (units_q < UW'(MAX_UNITS)) units_d = units_q + 1'b1;
      end else begin
        presc_d = presc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      units_q <= '0;
    end else if (clear || run) begin
      presc_q <= presc_d;
      units_q <= units_d;
    end
  end

  assign units = units_q;

  // R9: a restart leaves no counted time behind
  assert_clear_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (units == '0));

  // R4: count saturates at the longest wait
  assert_units_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    units <= UW'(MAX_UNITS));
endmodule

// File: rtl/osc_delay_flag.sv
module osc_delay_flag #(
  parameter int UW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          armed,
  input  logic [UW-1:0] units,
  input  logic [UW-1:0] target,
  output logic          reached
);
  logic flag_q, flag_d;

  always_comb begin
    if (clear)                          flag_d = 1'b0;
    else if (armed && units >= target)  flag_d = 1'b1;
    else                                flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign reached = flag_q;

  // R3/R4: a wait never ends before its unit target is counted
  assert_no_early_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reached) |-> (units >= target));
endmodule

// File: rtl/osc_startup_seq.sv
module osc_startup_seq
  import osc_seq_pkg::*;
#(
  parameter int UNIT_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down,
  input  logic [1:0] stab_code,
  input  logic [2:0] rel_code,
  input  logic       gate_override,
  input  logic       detect_en,
  output logic       osc_power_en,
  output logic       osc_stable,
  output logic       xtal_ok,
  output logic       clk_release_en
);
  pwr_state_t        state_q, state_d;
  logic [1:0]        stab_q;
  logic [2:0]        rel_q;
  logic              start, clear, armed, run;
  logic [UNIT_W-1:0] units;
  logic              stab_done, rel_done;
  logic              ok_q, ok_d, rel_en_q, rel_en_d;

  assign start = (state_q == PWR_OFF) && !pwr_down;
  assign clear = start || pwr_down;
  assign armed = (state_q != PWR_OFF);
  assign run   = (state_q == PWR_WAIT) && !pwr_down;

  // Power sequencing next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWR_OFF:   if (!pwr_down) state_d = PWR_WAIT;
      PWR_WAIT:  if (pwr_down) state_d = PWR_OFF;
                 else if (stab_done && rel_done) state_d = PWR_READY;
      PWR_READY: if (pwr_down) state_d = PWR_OFF;
      default:   state_d = PWR_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PWR_OFF;
    else        state_q <= state_d;
  end

  // Delay codes captured once per power-up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stab_q <= '0;
      rel_q  <= '0;
    end else if (start) begin
      stab_q <= stab_code;
      rel_q  <= rel_code;
    end
  end

  osc_unit_timer #(
    .UNIT_CYCLES(UNIT_CYCLES),
    .MAX_UNITS  (MAX_UNITS),
    .UW         (UNIT_W)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear),
    .run  (run),
    .units(units)
  );

  osc_delay_flag #(.UW(UNIT_W)) u_stab (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .armed  (armed),
    .units  (units),
    .target (stab_units(stab_q)),
    .reached(stab_done)
  );

  osc_delay_flag #(.UW(UNIT_W)) u_rel (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .armed  (armed),
    .units  (units),
    .target (rel_units(rel_q)),
    .reached(rel_done)
  );

  // Registered status and gate enable
  always_comb begin
    ok_d     = detect_en && stab_done && !clear;
    rel_en_d = gate_override || (rel_done && !clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q     <= 1'b0;
      rel_en_q <= 1'b0;
    end else begin
      ok_q     <= ok_d;
      rel_en_q <= rel_en_d;
    end
  end

  assign osc_power_en   = armed;
  assign osc_stable     = stab_done;
  assign xtal_ok        = ok_q;
  assign clk_release_en = rel_en_q;

  assert_stable_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stable |-> osc_power_en);

  assert_down_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!osc_power_en && !osc_stable && !xtal_ok));

  assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_override |=> clk_release_en);

  assert_detect_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !detect_en |=> !xtal_ok);

  assert_codes_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> ($stable(stab_q) && $stable(rel_q)));
endmodule

// File: tb/osc_startup_seq_test.sv
module osc_startup_seq_test;
  localparam int U = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_down = 1'b1;
  logic [1:0] stab_code = '0;
  logic [2:0] rel_code = '0;
  logic       gate_override = 1'b0;
  logic       detect_en = 1'b1;
  logic       osc_power_en, osc_stable, xtal_ok, clk_release_en;

  int checks = 0;
  int fails  = 0;
  int m_st, m_ok, m_rel;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  osc_startup_seq #(.UNIT_CYCLES(U)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .stab_code(stab_code),
    .rel_code(rel_code), .gate_override(gate_override), .detect_en(detect_en),
    .osc_power_en(osc_power_en), .osc_stable(osc_stable), .xtal_ok(xtal_ok),
    .clk_release_en(clk_release_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Power up from off and measure edges from enable rise to each status rise
  task automatic measure(input logic [1:0] sc, input logic [2:0] rc, input bit chg);
    m_st = -1; m_ok = -1; m_rel = -1;
    @(negedge clk);
    stab_code = sc; rel_code = rc; pwr_down = 1'b0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (i == 0) chk("R2 power enable rises", osc_power_en, 1);
      if (chg && i == 2) begin stab_code = 2'd3; rel_code = 3'd7; end
      if (osc_stable && m_st < 0) m_st = i;
      if (xtal_ok && m_ok < 0) m_ok = i;
      if (clk_release_en && m_rel < 0) m_rel = i;
    end
  endtask

  task automatic power_off_check;
    @(negedge clk); pwr_down = 1'b1;
    @(negedge clk);
    chk("R2 enable off", osc_power_en, 0);
    chk("R2 stable off", osc_stable, 0);
    chk("R2 xtal_ok off", xtal_ok, 0);
    chk("R2 release follows override", clk_release_en, gate_override);
  endtask

  task automatic t_reset;
    chk("R1 enable", osc_power_en, 0);
    chk("R1 stable", osc_stable, 0);
    chk("R1 xtal_ok", xtal_ok, 0);
    chk("R1 release", clk_release_en, 0);
  endtask

  task automatic t_delays(input logic [1:0] sc, input logic [2:0] rc);
    int s, r;
    s = 1 << sc;
    r = (rc == 0) ? 2 : 4 * rc;
    measure(sc, rc, 1'b0);
    chk("R3 stable delay", m_st, s * U + 1);
    chk("R6 xtal_ok lag", m_ok, s * U + 2);
    chk("R4 release delay", m_rel, r * U + 2);
    chk("R5 stable held", osc_stable, 1);
    power_off_check();
  endtask

  task automatic t_detect_off;
    detect_en = 1'b0;
    measure(2'd0, 3'd0, 1'b0);
    chk("R6 xtal_ok held low", m_ok, -1);
    chk("R6 stable unaffected", m_st, U + 1);
    power_off_check();
    detect_en = 1'b1;
  endtask

  task automatic t_override;
    @(negedge clk); gate_override = 1'b1;
    @(negedge clk);
    chk("R7 release while off", clk_release_en, 1);
    chk("R7 still powered down", osc_power_en, 0);
    measure(2'd1, 3'd2, 1'b0);
    chk("R7 release at first cycle", m_rel, 0);
    power_off_check();
    @(negedge clk); gate_override = 1'b0;
    @(negedge clk);
    chk("R7 release drops without override", clk_release_en, 0);
  endtask

  task automatic t_code_change;
    measure(2'd0, 3'd1, 1'b1);
    chk("R8 stable uses captured code", m_st, U + 1);
    chk("R8 release uses captured code", m_rel, 4 * U + 2);
    power_off_check();
  endtask

  task automatic t_restart;
    @(negedge clk); stab_code = 2'd3; rel_code = 3'd7; pwr_down = 1'b0;
    repeat (20) @(negedge clk);
    pwr_down = 1'b1;
    @(negedge clk);
    chk("R9 interrupted stable cleared", osc_stable, 0);
    measure(2'd3, 3'd7, 1'b0);
    chk("R9 stable full wait after restart", m_st, 8 * U + 1);
    chk("R9 release full wait after restart", m_rel, 28 * U + 2);
    power_off_check();
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_delays(2'd0, 3'd0);
    t_delays(2'd1, 3'd3);
    t_delays(2'd3, 3'd7);
    t_delays(2'd2, 3'd1);
    t_detect_off();
    t_override();
    t_code_change();
    t_restart();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule